// File: doc/BRIEF.md
# IR pulse-width capture controller

This block times a demodulated infrared receiver line and keeps the length of each mark (IR active) and each gap (IR idle) that follows it. Lengths are counted in sample ticks. One tick lasts a programmable number of periods of a divided clock, and that divided clock runs at one quarter of the block clock. Each length is an 8-bit count. Counts go into a bank of byte slots that software reads back as 32-bit words.

Capture begins at the first active level. It stops, and an interrupt request is raised, in either of two cases: a gap runs long enough to saturate its counter, which is taken as the end of a message, or every slot has been filled. The captured data then stays frozen until software issues a restart, which also empties the bank. Software clears the interrupt with a separate acknowledge write. All control goes through a flat register port with an 8-bit byte address and 32-bit data. Writes take effect on the clock edge. Reads are combinational while the port is selected.

Top module: `irw_capture_top`

## Requirements
- R1: After reset every readable register returns 0, all capture words read 0 and `irq_o` is low.
- R2: Capture runs only while both bit 0 and bit 13 of the control word at offset 0x0C are 1. With either bit clear, input activity leaves the bank and the interrupt untouched.
- R3: The tick length is the 13-bit field in bits 20:8 of offset 0x10, counted in periods of the clock divided by 4 (a value of 0 behaves as 1). A level that lasts L block-clock cycles is recorded as floor((L-1)/(4*period)) ticks.
- R4: The first recorded entry is a mark, and marks and gaps then alternate. Entry n is held in byte n mod 4 of the capture word at offset 0x88 + 4*(n div 4), with the earliest entry in bits 7:0. There are 17 words.
- R5: A mark longer than 255 ticks is recorded as 0xFF.
- R6: A gap that reaches 255 ticks is written as 0xFF, ends the message, stops capture and sets the interrupt status.
- R7: When the 68th entry is written, capture stops and the interrupt status is set.
- R8: Once capture has stopped, input edges change neither the bank nor the interrupt status until a restart.
- R9: Writing 1 to bit 0 at offset 0x20 zeroes all capture words and returns the receiver to waiting for a first active level.
- R10: `irq_o` is the interrupt status ANDed with bit 0 at offset 0xCC. Writing 1 to bit 0 at offset 0xD0 clears the status. If a completion and an acknowledge arrive in the same cycle, the completion wins.
- R11: Reads of unmapped or misaligned offsets, and reads of offsets 0x20 and 0xD0, return 0. Writes to capture words are ignored.
- R12: Offset 0x0C reads back only bits 0 and 13. Offset 0x10 reads back only bits 20:8. Offset 0xCC reads back only bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register port select |
| bus_we | input | 1 | Write strobe, qualified by `bus_en` |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_en` is high and `bus_we` is low |
| ir_rx | input | 1 | Demodulated IR line, active low by default |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are the completion that sets the interrupt status and the software acknowledge that clears it. The bench fills all 68 slots with one-tick entries. It then issues the acknowledge write two clock periods after the final input transition, so the write lands on the same edge at which the two synchronizer stages and the receive state machine register the last entry. The result is judged at the ports: `irq_o` must stay high, every capture word must hold 0x01010101, and a later acknowledge on its own must drop the request.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_CFG_HI   = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_CFG_LO   = 8'h10;
  localparam logic [REG_AW-1:0] OFF_RESTART  = 8'h20;
  localparam logic [REG_AW-1:0] OFF_CAP_BASE = 8'h88;
  localparam logic [REG_AW-1:0] OFF_IRQ_EN   = 8'hCC;
  localparam logic [REG_AW-1:0] OFF_IRQ_ACK  = 8'hD0;

  localparam int unsigned BIT_RX_EN = 0;
  localparam int unsigned BIT_PW_EN = 13;
  localparam int unsigned PER_LSB   = 8;
  localparam int unsigned PER_W     = 13;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } irw_state_e;
endpackage

// File: rtl/irw_sampler.sv
module irw_sampler #(
  parameter int unsigned DIV        = 4,
  parameter int unsigned PER_W      = 13,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             cap_en,
  input  logic             seg_start,
  input  logic [PER_W-1:0] period,
  output logic             rx_act,
  output logic             tick
);
  localparam int unsigned DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic        IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [1:0]       sync_q;
  logic [DIV_W-1:0] div_q, div_d;
  logic [PER_W-1:0] smp_q, smp_d;
  logic [PER_W-1:0] per_m1;
  logic             div_wrap, smp_wrap;

  // two-stage synchronizer on the raw line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {2{IDLE_LVL}};
    else        sync_q <= {sync_q[0], ir_in};
  end

  generate
    if (ACTIVE_LOW) begin : g_act_low
      assign rx_act = ~sync_q[1];
    end else begin : g_act_high
      assign rx_act = sync_q[1];
    end
  endgenerate

  assign per_m1   = (period == '0) ? '0 : period - 1'b1;
  assign div_wrap = (div_q == DIV_LAST);
  assign smp_wrap = (smp_q == per_m1);

  always_comb begin
    div_d = div_q;
    smp_d = smp_q;
    if (seg_start || !cap_en) begin
      div_d = '0;
      smp_d = '0;
    end else begin
      div_d = div_wrap ? '0 : div_q + 1'b1;
      if (div_wrap) smp_d = smp_wrap ? '0 : smp_q + 1'b1;
    end
  end

  assign tick = cap_en && !seg_start && div_wrap && smp_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      smp_q <= '0;
    end else begin
      div_q <= div_d;
      smp_q <= smp_d;
    end
  end
endmodule

// File: rtl/irw_fsm.sv
module irw_fsm
  import irw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 68,
  parameter int unsigned WID_W     = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             restart,
  input  logic             rx_act,
  input  logic             tick,
  output logic             seg_start,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [WID_W-1:0] wr_data,
  output logic             done_pulse,
  output irw_state_e       state_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);
  localparam logic [WID_W-1:0] WID_MAX  = '1;

  irw_state_e       state_q, state_d;
  logic             lvl_q, lvl_d;   // 1: timing a mark
  logic [WID_W-1:0] wid_q, wid_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    lvl_d      = lvl_q;
    wid_d      = wid_q;
    idx_d      = idx_q;
    seg_start  = 1'b0;
    wr_en      = 1'b0;
    wr_data    = wid_q;
    done_pulse = 1'b0;
    if (restart) begin
      state_d = ST_IDLE;
      lvl_d   = 1'b0;
      wid_d   = '0;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cap_en && rx_act) begin
            state_d   = ST_RUN;
            lvl_d     = 1'b1;
            wid_d     = '0;
            idx_d     = '0;
            seg_start = 1'b1;
          end
        end
        ST_RUN: begin
          if (!cap_en) begin
            state_d = ST_IDLE;
            wid_d   = '0;
            idx_d   = '0;
          end else if (rx_act != lvl_q) begin
            wr_en     = 1'b1;
            seg_start = 1'b1;
            lvl_d     = ~lvl_q;
            wid_d     = '0;
            if (idx_q == LAST_IDX) begin
              state_d    = ST_DONE;
              done_pulse = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else if (tick) begin
            if (!lvl_q && (wid_q == WID_MAX - 1'b1)) begin
              wr_en      = 1'b1;
              wr_data    = WID_MAX;
              state_d    = ST_DONE;
              done_pulse = 1'b1;
            end else if (wid_q != WID_MAX) begin
              wid_d = wid_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_idx  = idx_q;
  assign state_o = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= 1'b0;
      wid_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      wid_q   <= wid_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/irw_bank.sv
module irw_bank #(
  parameter int unsigned NUM_WORDS = 17,
  parameter int unsigned LANES     = 4,
  parameter int unsigned WID_W     = 8,
  localparam int unsigned NUM_SLOTS = NUM_WORDS * LANES,
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS),
  localparam int unsigned FLAT_W    = NUM_SLOTS * WID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WID_W-1:0]  wr_data,
  output logic [FLAT_W-1:0] cap_flat
);
  logic [WID_W-1:0] slot_q [NUM_SLOTS];
  logic             slot_ce [NUM_SLOTS];

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      slot_ce[s] = clr || (wr_en && (wr_idx == IDX_W'(s)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) slot_q[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (slot_ce[s]) slot_q[s] <= clr ? '0 : wr_data;
      end
    end
  end

  // slot order equals word order with the earliest slot in the low byte
  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pack
      assign cap_flat[g*WID_W +: WID_W] = slot_q[g];
    end
  endgenerate
endmodule

// File: rtl/irw_regs.sv
module irw_regs
  import irw_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 17,
  localparam int unsigned FLAT_W   = NUM_WORDS * REG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  input  logic [FLAT_W-1:0] cap_flat,
  input  logic              done_pulse,
  output logic              cap_en,
  output logic [PER_W-1:0]  period,
  output logic              restart,
  output logic              irq_stat,
  output logic              irq_o
);
  localparam int unsigned CAP_END = int'(OFF_CAP_BASE) + 4 * NUM_WORDS;

  logic             rx_en_q, rx_en_d;
  logic             pw_en_q, pw_en_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             irq_en_q, irq_en_d;
  logic             stat_q, stat_d;
  logic             wr, ack;
  logic [REG_AW-1:0] cap_off;
  logic             cap_hit;
  logic [REG_DW-1:0] cap_rd;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr      = bus_en && bus_we;
  assign restart = wr && (bus_addr == OFF_RESTART) && bus_wdata[0];
  assign ack     = wr && (bus_addr == OFF_IRQ_ACK) && bus_wdata[0];

  assign cap_off = bus_addr - OFF_CAP_BASE;
  assign cap_hit = (bus_addr >= OFF_CAP_BASE) && (int'(bus_addr) < CAP_END) &&
                   (bus_addr[1:0] == 2'b00);

  always_comb begin
    cap_rd = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (cap_off[REG_AW-1:2] == (REG_AW-2)'(i)) cap_rd = cap_flat[i*REG_DW +: REG_DW];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (bus_addr)
        OFF_CFG_HI: begin
          bus_rdata[BIT_RX_EN] = rx_en_q;
          bus_rdata[BIT_PW_EN] = pw_en_q;
        end
        OFF_CFG_LO: bus_rdata[PER_LSB +: PER_W] = per_q;
        OFF_IRQ_EN: bus_rdata[0] = irq_en_q;
        default:    if (cap_hit) bus_rdata = cap_rd;
      endcase
    end
  end

  always_comb begin
    rx_en_d  = rx_en_q;
    pw_en_d  = pw_en_q;
    per_d    = per_q;
    irq_en_d = irq_en_q;
    if (wr) begin
      unique case (bus_addr)
        OFF_CFG_HI: begin
          rx_en_d = bus_wdata[BIT_RX_EN];
          pw_en_d = bus_wdata[BIT_PW_EN];
        end
        OFF_CFG_LO: per_d    = bus_wdata[PER_LSB +: PER_W];
        OFF_IRQ_EN: irq_en_d = bus_wdata[0];
        default: ;
      endcase
    end
    // completion has priority over acknowledge
    stat_d = done_pulse || (stat_q && !ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      pw_en_q  <= 1'b0;
      per_q    <= '0;
      irq_en_q <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      rx_en_q  <= rx_en_d;
      pw_en_q  <= pw_en_d;
      per_q    <= per_d;
      irq_en_q <= irq_en_d;
      stat_q   <= stat_d;
    end
  end

  assign cap_en   = rx_en_q && pw_en_q;
  assign period   = per_q;
  assign irq_stat = stat_q;
  assign irq_o    = stat_q && irq_en_q;
endmodule

// File: rtl/irw_capture_top.sv
module irw_capture_top
  import irw_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 17,
  parameter int unsigned DIV        = 4,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ir_rx,
  output logic        irq_o
);
  localparam int unsigned WID_W     = 8;
  localparam int unsigned LANES     = REG_DW / WID_W;
  localparam int unsigned NUM_SLOTS = NUM_WORDS * LANES;
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);
  localparam int unsigned FLAT_W    = NUM_SLOTS * WID_W;

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic             cap_en, restart_pulse, done_pulse, irq_stat;
  logic [PER_W-1:0] period;
  logic             rx_act, tick, seg_start;
  logic             bank_wr;
  logic [IDX_W-1:0] bank_idx;
  logic [WID_W-1:0] bank_data;
  logic [FLAT_W-1:0] cap_flat;
  irw_state_e       fsm_state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  irw_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cap_flat   (cap_flat),
    .done_pulse (done_pulse),
    .cap_en     (cap_en),
    .period     (period),
    .restart    (restart_pulse),
    .irq_stat   (irq_stat),
    .irq_o      (irq_o)
  );

  irw_sampler #(.DIV(DIV), .PER_W(PER_W), .ACTIVE_LOW(ACTIVE_LOW)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ir_in     (ir_rx),
    .cap_en    (cap_en),
    .seg_start (seg_start),
    .period    (period),
    .rx_act    (rx_act),
    .tick      (tick)
  );

  irw_fsm #(.NUM_SLOTS(NUM_SLOTS), .WID_W(WID_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cap_en     (cap_en),
    .restart    (restart_pulse),
    .rx_act     (rx_act),
    .tick       (tick),
    .seg_start  (seg_start),
    .wr_en      (bank_wr),
    .wr_idx     (bank_idx),
    .wr_data    (bank_data),
    .done_pulse (done_pulse),
    .state_o    (fsm_state)
  );

  irw_bank #(.NUM_WORDS(NUM_WORDS), .LANES(LANES), .WID_W(WID_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (restart_pulse),
    .wr_en    (bank_wr),
    .wr_idx   (bank_idx),
    .wr_data  (bank_data),
    .cap_flat (cap_flat)
  );
endmodule

// File: rtl/irw_capture_chk.sv
module irw_capture_chk
  import irw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 68,
  parameter int unsigned IDX_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic             bank_wr,
  input logic [IDX_W-1:0] bank_idx,
  input irw_state_e       fsm_state,
  input logic             restart_pulse,
  input logic             done_pulse,
  input logic             irq_stat
);
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> (int'(bank_idx) < NUM_SLOTS)); // R7

  AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !bank_wr); // R2

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_DONE && !restart_pulse) |=> (fsm_state == ST_DONE)); // R8

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_DONE) |-> !bank_wr); // R8

  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> (fsm_state == ST_IDLE)); // R9

  AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(done_pulse)); // R10

  AST_DONE_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> irq_stat); // R10
endmodule

bind irw_capture_top irw_capture_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .cap_en        (cap_en),
  .bank_wr       (bank_wr),
  .bank_idx      (bank_idx),
  .fsm_state     (fsm_state),
  .restart_pulse (restart_pulse),
  .done_pulse    (done_pulse),
  .irq_stat      (irq_stat)
);

// File: tb/test_irw_capture_top.sv
`timescale 1ns/1ps
module test_irw_capture_top;
  localparam logic ACT = 1'b0;
  localparam logic SPC = 1'b1;
  localparam int   TICK_CYC = 8;   // period field 2, divide by 4

  // {mark0, gap0, mark1, expected word 0}
  localparam logic [55:0] VECS [4] = '{
    {8'd3,  8'd5,  8'd2,   32'hFF020503},
    {8'd1,  8'd1,  8'd1,   32'hFF010101},
    {8'd10, 8'd20, 8'd7,   32'hFF07140A},
    {8'd0,  8'd4,  8'd250, 32'hFFFA0400}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ir_rx;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  irw_capture_top i_irw_capture_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ir_rx(ir_rx), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_now(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic seg(input logic lvl, input int ticks);
    ir_rx = lvl;
    hold(ticks * TICK_CYC + TICK_CYC / 2);
  endtask

  task automatic wait_irq(input int limit);
    int n = 0;
    while (!irq_o && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ir_rx = SPC;
    hold(5);
    rst_n = 1'b1;
    hold(4);

    // R1 reset state
    reg_read(8'h0C, rd); check("R1 cfg_hi", rd, 32'h0);
    reg_read(8'h10, rd); check("R1 cfg_lo", rd, 32'h0);
    reg_read(8'hCC, rd); check("R1 irq_en", rd, 32'h0);
    reg_read(8'h88, rd); check("R1 word0", rd, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R12 readback masks
    reg_write(8'h0C, 32'hFFFF_FFFF); reg_read(8'h0C, rd); check("R12 cfg_hi", rd, 32'h0000_2001);
    reg_write(8'h10, 32'hFFFF_FFFF); reg_read(8'h10, rd); check("R12 cfg_lo", rd, 32'h001F_FF00);
    reg_write(8'hCC, 32'hFFFF_FFFF); reg_read(8'hCC, rd); check("R12 irq_en", rd, 32'h1);

    // R2 only one enable bit set: nothing captured
    reg_write(8'h0C, 32'h0000_0001);
    reg_write(8'h10, 32'h0000_0200);
    seg(ACT, 3); seg(SPC, 2); seg(ACT, 1); ir_rx = SPC; hold(2200);
    reg_read(8'h88, rd); check("R2 word0 disabled", rd, 32'h0);
    check("R2 irq disabled", {31'b0, irq_o}, 32'h0);
    reg_write(8'h0C, 32'h0000_2001);

    // R3 R4 R6 R10 vector table
    for (int v = 0; v < 4; v++) begin
      reg_write(8'h20, 32'h1);
      seg(ACT, int'(VECS[v][55:48]));
      seg(SPC, int'(VECS[v][47:40]));
      seg(ACT, int'(VECS[v][39:32]));
      ir_rx = SPC;
      wait_irq(4000);
      check("R6 end-of-message irq", {31'b0, irq_o}, 32'h1);
      reg_read(8'h88, rd); check("R3 R4 word0", rd, VECS[v][31:0]);
      reg_read(8'h8C, rd); check("R4 word1", rd, 32'h0);
      reg_write(8'hD0, 32'h1);
      #1 check("R10 ack", {31'b0, irq_o}, 32'h0);
    end

    // R5 mark saturates
    reg_write(8'h20, 32'h1);
    seg(ACT, 300); seg(SPC, 2); seg(ACT, 1); ir_rx = SPC;
    wait_irq(4000);
    reg_read(8'h88, rd); check("R5 saturated mark", rd, 32'hFF01_02FF);
    reg_write(8'hD0, 32'h1);

    // R10 enable gating
    reg_write(8'hCC, 32'h0);
    reg_write(8'h20, 32'h1);
    seg(ACT, 1); ir_rx = SPC; hold(2200);
    check("R10 gated", {31'b0, irq_o}, 32'h0);
    reg_read(8'h88, rd); check("R6 gated word0", rd, 32'h0000_FF01);
    reg_write(8'hCC, 32'h1);
    #1 check("R10 ungated", {31'b0, irq_o}, 32'h1);
    reg_write(8'hD0, 32'h1);
    #1 check("R10 cleared", {31'b0, irq_o}, 32'h0);

    // R7 bank fill, completion and acknowledge in the same cycle
    reg_write(8'h20, 32'h1);
    @(negedge clk);
    ir_rx = ACT;
    for (int k = 0; k < 67; k++) begin
      hold(12);
      ir_rx = ~ir_rx;
    end
    hold(12);
    ir_rx = ~ir_rx;
    hold(2);
    wr_now(8'hD0, 32'h1);
    #1 check("R10 set beats ack", {31'b0, irq_o}, 32'h1);
    for (int w = 0; w < 17; w++) begin
      reg_read(8'h88 + 8'(4 * w), rd);
      check("R7 full bank", rd, 32'h0101_0101);
    end

    // R8 frozen after completion
    reg_write(8'hD0, 32'h1);
    #1 check("R8 ack", {31'b0, irq_o}, 32'h0);
    seg(ACT, 2); seg(SPC, 1); seg(ACT, 1); ir_rx = SPC; hold(2200);
    check("R8 no new irq", {31'b0, irq_o}, 32'h0);
    reg_read(8'h88, rd); check("R8 word0 kept", rd, 32'h0101_0101);
    reg_read(8'hC8, rd); check("R8 word16 kept", rd, 32'h0101_0101);

    // R11 unmapped, misaligned, write-only and read-only
    reg_write(8'h88, 32'h1234_5678);
    reg_read(8'h88, rd); check("R11 capture write ignored", rd, 32'h0101_0101);
    reg_read(8'h04, rd); check("R11 unmapped", rd, 32'h0);
    reg_read(8'hFC, rd); check("R11 unmapped high", rd, 32'h0);
    reg_read(8'h8A, rd); check("R11 misaligned", rd, 32'h0);
    reg_read(8'h20, rd); check("R11 restart reads 0", rd, 32'h0);
    reg_read(8'hD0, rd); check("R11 ack reads 0", rd, 32'h0);

    // R9 restart clears and re-arms
    reg_write(8'h20, 32'h1);
    for (int w = 0; w < 17; w++) begin
      reg_read(8'h88 + 8'(4 * w), rd);
      check("R9 cleared", rd, 32'h0);
    end
    seg(ACT, 2); ir_rx = SPC;
    wait_irq(4000);
    check("R9 re-armed irq", {31'b0, irq_o}, 32'h1);
    reg_read(8'h88, rd); check("R9 re-armed word0", rd, 32'h0000_FF02);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule